// File: doc/BRIEF.md
# Programmed-I/O Frame Buffer Network Interface

This block is a byte-at-a-time network interface driven entirely by register accesses on a 32-bit bus with a 6-bit word address. An incoming byte stream fills a receive buffer with one whole frame. The host then pulls that frame out one byte per read of a data register. For transmission the host sets a length, pushes the bytes one per write, and the block plays the frame out on an outgoing byte stream as soon as the last byte lands. Three pending flags drive a level interrupt: transmit done, receive done and a test flag. A busy flag blocks reception until the host acknowledges the flags.

Reception runs a three-state machine. RX_IDLE waits for a frame and is ready only while reception is allowed. The first byte of a multi-byte frame moves it to RX_FILL, and a single-byte frame commits straight from RX_IDLE. RX_FILL commits on the last byte, returns to RX_IDLE, and moves to RX_DROP if the 1514th byte arrives before the last one. RX_DROP consumes bytes until the last one and then returns to RX_IDLE. Transmission has two states. TX_IDLE moves to TX_PLAY when the final byte is written. TX_PLAY returns to TX_IDLE when the last byte is taken. A soft reset sends both machines back to their idle states.

Top module: `pio_frame_nic`

## Requirements
- R1: Offset 0x00 reads 0x4D495053 and offset 0x04 reads 0x4E455430, both read-only. Offset 0x18, offset 0x20 and every unmapped offset read 0. Writes to read-only or unmapped offsets change nothing.
- R2: After hardware reset, busy (offset 0x08, bit 0) reads 1. The receive count (0x0C), the transmit count (0x10) and the flag register (0x14) read 0, and irq is low.
- R3: irq is high exactly when any flag in 0x14 is set. The flags are transmit-done at bit 0, receive-done at bit 1 and test at bit 31.
- R4: A read of 0x14 returns the current flags and then clears bit 31.
- R5: A write to 0x14 acts on the first match only. If bit 0 is set, it clears transmit-done. Otherwise, if bit 1 is set, it clears receive-done. Otherwise, if bit 31 is set, it performs a soft reset (R12). After any write to 0x14, busy equals the OR of the flags.
- R6: rx_ready in RX_IDLE is high only when busy is 0 and the receive count is below 1514. A committed frame sets the receive count to its length, resets the read position, sets busy and sets receive-done.
- R7: A frame of 1514 bytes or more is consumed up to its last byte. It leaves the count, the flags and busy unchanged.
- R8: Each read of 0x1C returns the next stored byte in bits 7:0 and decrements the receive count. When the count is 0, the read returns 0 and changes nothing.
- R9: A write to 0x10 loads the value if it is at most 1514 and loads 0 otherwise. Either way it restarts the transmit write position.
- R10: Each write to 0x20 stores bits 7:0. When the number of stored bytes equals the transmit count or reaches 1514, the frame plays out in order with tx_last on its final byte. Playout clears the count, sets transmit-done and sets busy. While tx_ready is low, tx_valid and tx_data hold steady.
- R11: Writes to 0x20 during playout are ignored.
- R12: A soft reset clears both counts, both positions and all flags, and returns both machines to idle. It then sets the test flag, so busy reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid during the read strobe |
| irq | output | 1 | Level interrupt |
| rx_data | input | 8 | Incoming frame byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_last | input | 1 | Marks the final byte of the incoming frame |
| rx_ready | output | 1 | Block can take the incoming byte |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_last | output | 1 | Marks the final byte of the outgoing frame |
| tx_ready | input | 1 | Sink takes the outgoing byte |

## Verification
The bench covers five corner cases.
- A flag write with both done bits set must clear only transmit-done. A design with the priority reversed leaves receive-done clear and the wrong bit set.
- A 1514-byte frame must be dropped while a 1513-byte frame is kept. An off-by-one limit either commits the oversized frame or loses the largest legal one.
- Draining the receive buffer past empty must return 0 and leave the count at 0. A design without that guard wraps the count.
- Rewriting the transmit count partway through a frame must restart the write position, so that only the new bytes leave. A transmit data write made during a stalled playout must not start a second frame.
- A test-bit write must wipe the counts and yet leave the test flag set. A later read of the flag register must clear that flag.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam logic [5:0] OFS_ID_HI    = 6'h00;
    localparam logic [5:0] OFS_ID_LO    = 6'h04;
    localparam logic [5:0] OFS_BUSY     = 6'h08;
    localparam logic [5:0] OFS_RX_CNT   = 6'h0C;
    localparam logic [5:0] OFS_TX_CNT   = 6'h10;
    localparam logic [5:0] OFS_FLAGS    = 6'h14;
    localparam logic [5:0] OFS_IRQ_INFO = 6'h18;
    localparam logic [5:0] OFS_RX_DATA  = 6'h1C;
    localparam logic [5:0] OFS_TX_DATA  = 6'h20;

    localparam logic [31:0] ID_WORD_HI = 32'h4D49_5053;
    localparam logic [31:0] ID_WORD_LO = 32'h4E45_5430;

    typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_DROP} rx_state_t;
    typedef enum logic {TX_IDLE, TX_PLAY} tx_state_t;
endpackage

// File: rtl/nic_rx_buf.sv
module nic_rx_buf
    import nic_pkg::*;
#(
    parameter int BUF_BYTES = 1514,
    parameter int CW        = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          accept_ok,
    input  logic [7:0]    s_data,
    input  logic          s_valid,
    input  logic          s_last,
    output logic          s_ready,
    input  logic [CW-1:0] rd_addr,
    output logic [7:0]    rd_byte,
    output logic          commit,
    output logic [CW-1:0] commit_len
);
    localparam logic [CW-1:0] LAST_SLOT = CW'(BUF_BYTES - 1);

    rx_state_t     state, state_n;
    logic [CW-1:0] idx;
    logic [7:0]    mem [BUF_BYTES];
    logic          take;

    assign take       = s_valid && s_ready;
    assign commit_len = idx + 1'b1;
    assign rd_byte    = mem[rd_addr];

    always_comb begin
        state_n = state;
        commit  = 1'b0;
        s_ready = 1'b1;
        unique case (state)
            RX_IDLE: begin
                s_ready = accept_ok;
                if (take) begin
                    if (s_last) commit = 1'b1;
                    else        state_n = RX_FILL;
                end
            end
            RX_FILL: begin
                if (take) begin
                    if (idx == LAST_SLOT)
                        state_n = s_last ? RX_IDLE : RX_DROP;
                    else if (s_last) begin
                        commit  = 1'b1;
                        state_n = RX_IDLE;
                    end
                end
            end
            RX_DROP: begin
                if (take && s_last) state_n = RX_IDLE;
            end
            default: state_n = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            idx   <= '0;
        end else if (soft_clr) begin
            state <= RX_IDLE;
            idx   <= '0;
        end else begin
            state <= state_n;
            if (take) idx <= (state_n == RX_FILL) ? idx + 1'b1 : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (take && state != RX_DROP && !soft_clr) mem[idx] <= s_data;
    end

    p_len_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (commit_len != '0) && (commit_len < CW'(BUF_BYTES)));
endmodule

// File: rtl/nic_tx_buf.sv
module nic_tx_buf
    import nic_pkg::*;
#(
    parameter int BUF_BYTES = 1514,
    parameter int CW        = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_idx,
    input  logic [7:0]    wr_byte,
    input  logic          launch,
    input  logic [CW-1:0] launch_len,
    output logic [7:0]    m_data,
    output logic          m_valid,
    output logic          m_last,
    input  logic          m_ready,
    output logic          playing
);
    tx_state_t     state, state_n;
    logic [CW-1:0] pidx, plen;
    logic [7:0]    mem [BUF_BYTES];

    always_comb begin
        state_n = state;
        unique case (state)
            TX_IDLE: if (launch) state_n = TX_PLAY;
            TX_PLAY: if (m_ready && m_last) state_n = TX_IDLE;
            default: state_n = TX_IDLE;
        endcase
    end

    always_comb begin
        playing = (state == TX_PLAY);
        m_valid = playing;
        m_data  = mem[pidx];
        m_last  = playing && (pidx == plen - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            pidx  <= '0;
            plen  <= '0;
        end else if (soft_clr) begin
            state <= TX_IDLE;
            pidx  <= '0;
        end else begin
            state <= state_n;
            if (state == TX_IDLE && launch) begin
                pidx <= '0;
                plen <= launch_len;
            end else if (playing && m_ready) begin
                pidx <= pidx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_byte;
    end

    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && !soft_clr) |=> m_valid && $stable(m_data) && $stable(m_last));
endmodule

// File: rtl/pio_frame_nic.sv
module pio_frame_nic
    import nic_pkg::*;
#(
    parameter int BUF_BYTES = 1514
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    input  logic        rx_last,
    output logic        rx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    input  logic        tx_ready
);
    localparam int CW = $clog2(BUF_BYTES + 1);
    localparam logic [CW-1:0] BUF_LIM = CW'(BUF_BYTES);

    logic          busy, flg_tx, flg_rx, flg_test;
    logic          busy_n, flg_tx_n, flg_rx_n, flg_test_n;
    logic [CW-1:0] rx_cnt, rx_rptr, tx_cnt, tx_wptr;
    logic [CW-1:0] rx_cnt_n, rx_rptr_n, tx_cnt_n, tx_wptr_n;
    logic          rd_acc, wr_acc, soft_clr, accept_ok, tx_wr_ok, launch;
    logic          commit, playing;
    logic [CW-1:0] commit_len, wptr_inc;
    logic [7:0]    rx_byte;

    assign rd_acc    = reg_en && !reg_we;
    assign wr_acc    = reg_en && reg_we;
    assign soft_clr  = wr_acc && (reg_addr == OFS_FLAGS) && !reg_wdata[0]
                       && !reg_wdata[1] && reg_wdata[31];
    assign accept_ok = !busy && (rx_cnt < BUF_LIM);
    assign tx_wr_ok  = wr_acc && (reg_addr == OFS_TX_DATA) && !playing;
    assign wptr_inc  = tx_wptr + 1'b1;
    assign launch    = tx_wr_ok && ((wptr_inc == tx_cnt) || (wptr_inc == BUF_LIM));
    assign irq       = flg_tx | flg_rx | flg_test;

    always_comb begin
        busy_n = busy;     flg_tx_n = flg_tx;   flg_rx_n = flg_rx;   flg_test_n = flg_test;
        rx_cnt_n = rx_cnt; rx_rptr_n = rx_rptr; tx_cnt_n = tx_cnt; tx_wptr_n = tx_wptr;
        if (soft_clr) begin
            rx_cnt_n = '0; rx_rptr_n = '0; tx_cnt_n = '0; tx_wptr_n = '0;
            flg_tx_n = 1'b0; flg_rx_n = 1'b0; flg_test_n = 1'b1; busy_n = 1'b1;
        end else begin
            if (rd_acc && reg_addr == OFS_FLAGS) flg_test_n = 1'b0;
            if (wr_acc && reg_addr == OFS_FLAGS) begin
                if (reg_wdata[0])      flg_tx_n = 1'b0;
                else if (reg_wdata[1]) flg_rx_n = 1'b0;
                busy_n = flg_tx_n | flg_rx_n | flg_test_n;
            end
            if (rd_acc && reg_addr == OFS_RX_DATA && rx_cnt != '0) begin
                rx_cnt_n  = rx_cnt - 1'b1;
                rx_rptr_n = rx_rptr + 1'b1;
            end
            if (wr_acc && reg_addr == OFS_TX_CNT) begin
                tx_cnt_n  = (reg_wdata <= 32'(BUF_BYTES)) ? reg_wdata[CW-1:0] : '0;
                tx_wptr_n = '0;
            end
            if (tx_wr_ok) begin
                tx_wptr_n = wptr_inc;
                if (launch) begin
                    tx_cnt_n = '0; tx_wptr_n = '0; flg_tx_n = 1'b1; busy_n = 1'b1;
                end
            end
            if (commit) begin
                rx_cnt_n = commit_len; rx_rptr_n = '0; flg_rx_n = 1'b1; busy_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b1; flg_tx <= 1'b0; flg_rx <= 1'b0; flg_test <= 1'b0;
            rx_cnt <= '0; rx_rptr <= '0; tx_cnt <= '0; tx_wptr <= '0;
        end else begin
            busy <= busy_n; flg_tx <= flg_tx_n; flg_rx <= flg_rx_n; flg_test <= flg_test_n;
            rx_cnt <= rx_cnt_n; rx_rptr <= rx_rptr_n; tx_cnt <= tx_cnt_n; tx_wptr <= tx_wptr_n;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (rd_acc) begin
            unique case (reg_addr)
                OFS_ID_HI:   reg_rdata = ID_WORD_HI;
                OFS_ID_LO:   reg_rdata = ID_WORD_LO;
                OFS_BUSY:    reg_rdata = {31'b0, busy};
                OFS_RX_CNT:  reg_rdata = 32'(rx_cnt);
                OFS_TX_CNT:  reg_rdata = 32'(tx_cnt);
                OFS_FLAGS:   reg_rdata = {flg_test, 29'b0, flg_rx, flg_tx};
                OFS_RX_DATA: reg_rdata = (rx_cnt != '0) ? {24'b0, rx_byte} : '0;
                default:     reg_rdata = '0;
            endcase
        end
    end

    nic_rx_buf #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_rx (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .accept_ok(accept_ok),
        .s_data(rx_data), .s_valid(rx_valid), .s_last(rx_last), .s_ready(rx_ready),
        .rd_addr(rx_rptr), .rd_byte(rx_byte), .commit(commit), .commit_len(commit_len)
    );

    nic_tx_buf #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_tx (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(tx_wr_ok),
        .wr_idx(tx_wptr), .wr_byte(reg_wdata[7:0]), .launch(launch), .launch_len(wptr_inc),
        .m_data(tx_data), .m_valid(tx_valid), .m_last(tx_last), .m_ready(tx_ready),
        .playing(playing)
    );

    p_rx_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && reg_addr == OFS_RX_DATA && rx_cnt != '0 && !commit)
        |=> rx_cnt == CW'($past(rx_cnt) - 1'b1));
    p_rx_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && reg_addr == OFS_RX_DATA && rx_cnt == '0) |-> (reg_rdata == '0));
    p_test_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && reg_addr == OFS_FLAGS) |=> !flg_test);
    p_busy_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && reg_addr == OFS_FLAGS && !commit) |=> busy == (flg_tx | flg_rx | flg_test));
endmodule

// File: tb/pio_frame_nic_test.sv
module pio_frame_nic_test;
    localparam logic [5:0] A_ID0 = 6'h00, A_ID1 = 6'h04, A_BUSY = 6'h08, A_RXC = 6'h0C;
    localparam logic [5:0] A_TXC = 6'h10, A_FLG = 6'h14, A_INFO = 6'h18, A_RXD = 6'h1C;
    localparam logic [5:0] A_TXD = 6'h20;

    logic clk = 0, rst_n = 0;
    logic reg_en = 0, reg_we = 0;
    logic [5:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic irq, rx_ready, tx_valid, tx_last, rx_valid = 0, rx_last = 0, tx_ready = 1;
    logic [7:0] rx_data = '0, tx_data;

    int n_chk = 0, n_fail = 0;
    logic [7:0] cap [16];
    int cap_n = 0, last_at = -1;

    always #10 clk = ~clk;

    pio_frame_nic uut (.*);

    initial forever begin
        @(negedge clk); #3;
        if (tx_valid && tx_ready && cap_n < 16) begin
            cap[cap_n] = tx_data;
            if (tx_last) last_at = cap_n;
            cap_n++;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_en = 0; reg_we = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk); reg_en = 0;
    endtask

    task automatic rd_chk(string tag, logic [5:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic send_rx(int len, logic [7:0] seed);
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            logic got;
            rx_data = seed + 8'(i); rx_valid = 1; rx_last = (i == len - 1);
            got = 0;
            while (!got) begin
                #1 got = rx_ready;
                @(negedge clk);
            end
        end
        rx_valid = 0; rx_last = 0;
    endtask

    task automatic t_reset;
        chk("R2 irq", irq, 0);
        rd_chk("R2 busy", A_BUSY, 1);
        rd_chk("R2 rx count", A_RXC, 0);
        rd_chk("R2 tx count", A_TXC, 0);
        rd_chk("R2 flags", A_FLG, 0);
        chk("R6 ready while busy", rx_ready, 0);
    endtask

    task automatic t_ident;
        rd_chk("R1 id hi", A_ID0, 32'h4D495053);
        rd_chk("R1 id lo", A_ID1, 32'h4E455430);
        rd_chk("R1 info", A_INFO, 0);
        rd_chk("R1 tx data", A_TXD, 0);
        rd_chk("R1 unmapped", 6'h3C, 0);
        wr(A_ID0, 32'h0);
        rd_chk("R1 id after write", A_ID0, 32'h4D495053);
    endtask

    task automatic t_rx_small;
        wr(A_FLG, 0);
        rd_chk("R5 busy after zero write", A_BUSY, 0);
        chk("R6 ready when free", rx_ready, 1);
        send_rx(5, 8'h11);
        chk("R3 irq on rx", irq, 1);
        chk("R6 ready after commit", rx_ready, 0);
        rd_chk("R6 rx count", A_RXC, 5);
        rd_chk("R6 busy", A_BUSY, 1);
        for (int i = 0; i < 5; i++) rd_chk("R8 rx byte", A_RXD, 32'(8'h11 + i));
        rd_chk("R8 count drained", A_RXC, 0);
        rd_chk("R8 empty read", A_RXD, 0);
        rd_chk("R8 count stays", A_RXC, 0);
    endtask

    task automatic t_tx_stall;
        @(negedge clk); #1 tx_ready = 0;
        cap_n = 0; last_at = -1;
        wr(A_TXC, 3);
        wr(A_TXD, 32'hA1); wr(A_TXD, 32'hA2); wr(A_TXD, 32'hA3);
        repeat (3) @(negedge clk);
        chk("R10 valid held", tx_valid, 1);
        chk("R10 data held", tx_data, 8'hA1);
        wr(A_TXD, 32'hEE);
        rd_chk("R10 count cleared", A_TXC, 0);
        @(negedge clk); #1 tx_ready = 1;
        repeat (8) @(negedge clk);
        chk("R11 byte count", cap_n, 3);
        chk("R10 byte0", cap[0], 8'hA1);
        chk("R10 byte2", cap[2], 8'hA3);
        chk("R10 last", last_at, 2);
        rd_chk("R10 flags both", A_FLG, 3);
    endtask

    task automatic t_ack_order;
        wr(A_FLG, 32'h8000_0003);
        rd_chk("R5 tx first", A_FLG, 2);
        rd_chk("R5 busy stays", A_BUSY, 1);
        wr(A_FLG, 32'h8000_0002);
        rd_chk("R5 rx next", A_FLG, 0);
        rd_chk("R5 busy free", A_BUSY, 0);
        chk("R3 irq low", irq, 0);
    endtask

    task automatic t_tx_count;
        wr(A_TXC, 1515);
        rd_chk("R9 too big", A_TXC, 0);
        wr(A_TXC, 1514);
        rd_chk("R9 max", A_TXC, 1514);
        cap_n = 0; last_at = -1;
        wr(A_TXC, 4);
        wr(A_TXD, 32'h31); wr(A_TXD, 32'h32);
        wr(A_TXC, 2);
        wr(A_TXD, 32'h141); wr(A_TXD, 32'h42);
        repeat (6) @(negedge clk);
        chk("R9 restart len", cap_n, 2);
        chk("R9 restart byte", cap[0], 8'h41);
        chk("R10 low byte", cap[1], 8'h42);
        wr(A_FLG, 1);
        rd_chk("R5 busy after tx ack", A_BUSY, 0);
    endtask

    task automatic t_rx_limits;
        send_rx(1514, 8'h00);
        rd_chk("R7 drop count", A_RXC, 0);
        rd_chk("R7 drop flags", A_FLG, 0);
        chk("R7 ready again", rx_ready, 1);
        send_rx(1513, 8'h70);
        rd_chk("R6 max frame", A_RXC, 1513);
        rd_chk("R6 rx done", A_FLG, 2);
        rd_chk("R8 first of max", A_RXD, 32'h70);
    endtask

    task automatic t_soft_reset;
        wr(A_TXC, 5);
        wr(A_TXD, 32'h99);
        wr(A_FLG, 32'h8000_0000);
        chk("R12 irq test", irq, 1);
        rd_chk("R12 rx count", A_RXC, 0);
        rd_chk("R12 tx count", A_TXC, 0);
        rd_chk("R12 busy", A_BUSY, 1);
        rd_chk("R4 test read", A_FLG, 32'h8000_0000);
        rd_chk("R4 test cleared", A_FLG, 0);
        chk("R3 irq after clear", irq, 0);
        wr(A_FLG, 0);
        rd_chk("R5 busy released", A_BUSY, 0);
        cap_n = 0; last_at = -1;
        wr(A_TXC, 1);
        wr(A_TXD, 32'h5A);
        repeat (4) @(negedge clk);
        chk("R12 position restarted", cap_n, 1);
        chk("R12 byte", cap[0], 8'h5A);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_rx_small();
        t_tx_stall();
        t_ack_order();
        t_tx_count();
        t_rx_limits();
        t_soft_reset();
        report();
    end
endmodule